// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a 32-bit CPU core and decides, every clock, whether a pending synchronous exception or an external hardware interrupt is taken. When one is taken, it computes the whole state change of entry to the handler in one step. It saves the status word, the program counter and the stack pointer register into their shadow copies. It raises the privilege, block and register-bank bits. It picks the handler address from the event class and records the cause code. A separate interrupt priority unit receives the current mask level from this block and answers with an accept flag and a vector code.

The core presents the pending exception code, where all ones means nothing is pending. It also presents the current PC, status word, R15, vector base, sleep flag and delay-slot flag. One clock after the inputs are sampled, the block raises a single-cycle load strobe and presents the new register values. The same strobe tells the core to clear its sleep flag. A companion strobe tells the core to clear its delay-slot flags when the event hit a delay slot.

Top module: `exc_entry_seq`

## Requirements
- R1: During and right after reset, every registered output (strobes, new PC, new SR, SSR, SPC, SGR, EXPEVT, INTEVT) reads zero.
- R2: If an exception code other than 0xFFF is presented while an interrupt is also requested, the exception is taken: EXPEVT is written and INTEVT keeps its value.
- R3: With the block bit (SR bit 28) set, any pending exception other than 0x1E0 is taken as code 0x000 (reset class). Code 0x1E0 keeps its own code and goes to VBR+0x100.
- R4: With SR bit 28 set, an interrupt request causes no load unless the sleep input is high, in which case it is taken normally.
- R5: `irq_mask_o` equals SR bits 7:4. An interrupt with `irq_ok_i` low causes no load and leaves all outputs unchanged.
- R6: On a taken event SSR gets SR, SGR gets R15 and SPC gets PC. The new SR is the old SR with bits 30 (privileged), 29 (bank) and 28 (block) set.
- R7: When the delay-slot input is high on a taken event, SPC is PC minus 2 and `ds_clr_o` pulses with the load strobe. Otherwise `ds_clr_o` stays low.
- R8: Codes 0x000, 0x020 and 0x140 also clear SR bit 15 (FPU disable), set SR bits 7:4 to 0xF and put 0xA0000000 in the new PC.
- R9: Codes 0x040 and 0x060 go to VBR+0x400.
- R10: Code 0x160 adds 2 to the saved SPC after any delay-slot adjustment. It and every other exception code not named in R8 or R9 go to VBR+0x100.
- R11: A taken interrupt writes the vector code into INTEVT, leaves EXPEVT unchanged and goes to VBR+0x600.
- R12: `load_o` and `wake_o` pulse for exactly the cycle after an event is sampled. Without an event all value outputs hold their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_code_i | input | 12 | Pending exception code, 0xFFF for none |
| irq_req_i | input | 1 | Hardware interrupt request |
| irq_ok_i | input | 1 | Priority unit accepts an interrupt at the given mask |
| irq_vec_i | input | 12 | Interrupt vector code from the priority unit |
| irq_mask_o | output | 4 | Current mask level (SR bits 7:4) for the priority unit |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| r15_i | input | 32 | Current R15 |
| vbr_i | input | 32 | Vector base |
| sleep_i | input | 1 | CPU is in sleep |
| ds_i | input | 1 | Current instruction is in a branch delay slot |
| load_o | output | 1 | Load strobe for all new values |
| wake_o | output | 1 | Clear the sleep flag |
| ds_clr_o | output | 1 | Clear the delay-slot flags |
| pc_o | output | 32 | New program counter |
| sr_o | output | 32 | New status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved R15 |
| expevt_o | output | 12 | Recorded exception code |
| intevt_o | output | 12 | Recorded interrupt code |

## Verification
On every cycle, the assertions check these rules: a loaded status word always carries the privileged, bank and block bits; the delay-slot strobe never appears without a load; an exception leaves INTEVT untouched; a remapped exception under the block bit lands at the reset address with code zero; an interrupt refused by the priority unit, or blocked while awake, never loads. The handler addresses for each class, the SPC arithmetic for traps and delay slots, the masking of FD and IMASK, and the holding of values between events can only be shown by the bench scenarios, which compare every output with a behavioural model each clock.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int CODE_W    = 12;
  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;
  localparam int SR_FD_BIT = 15;
  localparam int SR_IM_LSB = 4;
  localparam int SR_IM_W   = 4;

  localparam logic [CODE_W-1:0] CODE_NONE      = '1;
  localparam logic [CODE_W-1:0] CODE_PWR_RESET = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MAN_RESET = 12'h020;
  localparam logic [CODE_W-1:0] CODE_MULTI_HIT = 12'h140;
  localparam logic [CODE_W-1:0] CODE_MISS_RD   = 12'h040;
  localparam logic [CODE_W-1:0] CODE_MISS_WR   = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TRAP      = 12'h160;
  localparam logic [CODE_W-1:0] CODE_BL_KEEP   = 12'h1E0;

  localparam logic [31:0] RESET_TARGET = 32'hA000_0000;
  localparam logic [31:0] OFS_GENERAL  = 32'h0000_0100;
  localparam logic [31:0] OFS_MISS     = 32'h0000_0400;
  localparam logic [31:0] OFS_IRQ      = 32'h0000_0600;

  typedef enum logic [1:0] {EV_NONE = 2'd0, EV_EXC = 2'd1, EV_IRQ = 2'd2} ev_kind_e;
  typedef enum logic [1:0] {VC_RESET = 2'd0, VC_MISS = 2'd1, VC_GENERAL = 2'd2} vec_class_e;

  function automatic vec_class_e classify(input logic [CODE_W-1:0] c);
    if (c == CODE_PWR_RESET || c == CODE_MAN_RESET || c == CODE_MULTI_HIT)
      return VC_RESET;
    if (c == CODE_MISS_RD || c == CODE_MISS_WR)
      return VC_MISS;
    return VC_GENERAL;
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_ok_i,
  input  logic              blocked_i,
  input  logic              sleep_i,
  output ev_kind_e          kind_o,
  output logic [CODE_W-1:0] code_o
);
  logic exc_pend;
  logic irq_pend;

  always_comb begin
    exc_pend = (exc_code_i != CODE_NONE);
    irq_pend = irq_req_i && !exc_pend;
    kind_o   = EV_NONE;
    code_o   = exc_code_i;
    if (exc_pend) begin
      kind_o = EV_EXC;
      if (blocked_i && exc_code_i != CODE_BL_KEEP)
        code_o = CODE_PWR_RESET;
    end else if (irq_pend && (!blocked_i || sleep_i) && irq_ok_i) begin
      kind_o = EV_IRQ;
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ev_kind_e          kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              ds_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   spc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  vec_class_e cls;

  always_comb begin
    cls   = classify(code_i);
    spc_o = ds_i ? (pc_i - STEP) : pc_i;
    sr_o  = sr_i;
    sr_o[SR_BL_BIT] = 1'b1;
    sr_o[SR_MD_BIT] = 1'b1;
    sr_o[SR_RB_BIT] = 1'b1;
    pc_o  = vbr_i + XLEN'(OFS_GENERAL);
    if (kind_i == EV_IRQ) begin
      pc_o = vbr_i + XLEN'(OFS_IRQ);
    end else begin
      if (code_i == CODE_TRAP)
        spc_o = spc_o + STEP;
      case (cls)
        VC_RESET: begin
          sr_o[SR_FD_BIT] = 1'b0;
          sr_o[SR_IM_LSB +: SR_IM_W] = '1;
          pc_o = XLEN'(RESET_TARGET);
        end
        VC_MISS: pc_o = vbr_i + XLEN'(OFS_MISS);
        default: pc_o = vbr_i + XLEN'(OFS_GENERAL);
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_ok_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  output logic [SR_IM_W-1:0] irq_mask_o,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              sleep_i,
  input  logic              ds_i,
  output logic              load_o,
  output logic              wake_o,
  output logic              ds_clr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  assign irq_mask_o = sr_i[SR_IM_LSB +: SR_IM_W];

  ev_kind_e          kind;
  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   t_pc, t_sr, t_spc;
  logic              take;

  exc_arbiter u_arb (
    .exc_code_i (exc_code_i),
    .irq_req_i  (irq_req_i),
    .irq_ok_i   (irq_ok_i),
    .blocked_i  (sr_i[SR_BL_BIT]),
    .sleep_i    (sleep_i),
    .kind_o     (kind),
    .code_o     (eff_code)
  );

  exc_target #(.XLEN(XLEN)) u_tgt (
    .kind_i (kind),
    .code_i (eff_code),
    .pc_i   (pc_i),
    .sr_i   (sr_i),
    .vbr_i  (vbr_i),
    .ds_i   (ds_i),
    .pc_o   (t_pc),
    .sr_o   (t_sr),
    .spc_o  (t_spc)
  );

  // next-state
  logic              load_d, ds_clr_d;
  logic [CODE_W-1:0] expevt_d, intevt_d;

  always_comb begin
    take     = (kind != EV_NONE);
    load_d   = take;
    ds_clr_d = take && ds_i;
    expevt_d = expevt_o;
    intevt_d = intevt_o;
    if (kind == EV_EXC) expevt_d = eff_code;
    if (kind == EV_IRQ) intevt_d = irq_vec_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      load_o   <= 1'b0;
      wake_o   <= 1'b0;
      ds_clr_o <= 1'b0;
      pc_o     <= '0;
      sr_o     <= '0;
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      expevt_o <= '0;
      intevt_o <= '0;
    end else begin
      load_o   <= load_d;
      wake_o   <= load_d;
      ds_clr_o <= ds_clr_d;
      if (take) begin
        pc_o     <= t_pc;
        sr_o     <= t_sr;
        ssr_o    <= sr_i;
        spc_o    <= t_spc;
        sgr_o    <= r15_i;
        expevt_o <= expevt_d;
        intevt_o <= intevt_d;
      end
    end
  end

  // R6
  sr_entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_l)
    load_o |-> (sr_o[SR_BL_BIT] && sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT]));

  // R7
  ds_clr_with_load_chk: assert property (@(posedge clk) disable iff (!rst_l)
    ds_clr_o |-> load_o);

  // R2
  exc_beats_irq_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (exc_code_i != CODE_NONE) |=> (load_o && $stable(intevt_o)));

  // R3
  bl_remap_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (exc_code_i != CODE_NONE && exc_code_i != CODE_BL_KEEP && sr_i[SR_BL_BIT])
      |=> (expevt_o == CODE_PWR_RESET && pc_o == XLEN'(RESET_TARGET)));

  // R4
  bl_irq_awake_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (exc_code_i == CODE_NONE && sr_i[SR_BL_BIT] && !sleep_i) |=> !load_o);

  // R5
  irq_refused_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (exc_code_i == CODE_NONE && !irq_ok_i) |=> !load_o);
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] exc_code, irq_vec;
  logic        irq_req, irq_ok, sleep, ds;
  logic [31:0] pc, sr, r15, vbr;
  logic [3:0]  irq_mask;
  logic        load, wake, ds_clr;
  logic [31:0] pc_n, sr_n, ssr, spc, sgr;
  logic [11:0] expevt, intevt;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .exc_code_i(exc_code), .irq_req_i(irq_req),
    .irq_ok_i(irq_ok), .irq_vec_i(irq_vec), .irq_mask_o(irq_mask),
    .pc_i(pc), .sr_i(sr), .r15_i(r15), .vbr_i(vbr), .sleep_i(sleep), .ds_i(ds),
    .load_o(load), .wake_o(wake), .ds_clr_o(ds_clr), .pc_o(pc_n), .sr_o(sr_n),
    .ssr_o(ssr), .spc_o(spc), .sgr_o(sgr), .expevt_o(expevt), .intevt_o(intevt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit          m_load, m_wake, m_dsclr;
  logic [31:0] m_pc, m_sr, m_ssr, m_spc, m_sgr;
  logic [11:0] m_exp, m_int;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "load", 32'(load), 32'(m_load));
    chk(tag, "wake", 32'(wake), 32'(m_wake));
    chk(tag, "ds_clr", 32'(ds_clr), 32'(m_dsclr));
    chk(tag, "pc", pc_n, m_pc);
    chk(tag, "sr", sr_n, m_sr);
    chk(tag, "ssr", ssr, m_ssr);
    chk(tag, "spc", spc, m_spc);
    chk(tag, "sgr", sgr, m_sgr);
    chk(tag, "expevt", 32'(expevt), 32'(m_exp));
    chk(tag, "intevt", 32'(intevt), 32'(m_int));
  endtask

  task automatic model_step();
    logic [11:0] c;
    bit exc_p, irq_p, blk, take, is_irq;
    logic [31:0] s, p;
    c = exc_code;
    exc_p = (c != 12'hFFF);
    blk = sr[28];
    irq_p = irq_req && !exc_p;
    take = 0; is_irq = 0;
    if (blk && exc_p && c != 12'h1E0) c = 12'h000;
    if (exc_p) take = 1;
    else if (irq_p && (!blk || sleep) && irq_ok) begin take = 1; is_irq = 1; end
    m_load = take; m_wake = take; m_dsclr = take && ds;
    if (take) begin
      m_ssr = sr; m_sgr = r15;
      p = ds ? pc - 2 : pc;
      s = sr | 32'h7000_0000;
      if (is_irq) begin
        m_int = irq_vec; m_pc = vbr + 32'h600;
      end else begin
        m_exp = c;
        if (c == 12'h160) p = p + 2;
        if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
          s = (s & ~32'h0000_8000) | 32'h0000_00F0;
          m_pc = 32'hA000_0000;
        end else if (c == 12'h040 || c == 12'h060) m_pc = vbr + 32'h400;
        else m_pc = vbr + 32'h100;
      end
      m_spc = p; m_sr = s;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input string tag, input logic [11:0] e, input bit rq, input bit ok,
                      input logic [11:0] v, input logic [31:0] p, input logic [31:0] s,
                      input bit slp, input bit d);
    exc_code = e; irq_req = rq; irq_ok = ok; irq_vec = v;
    pc = p; sr = s; sleep = slp; ds = d;
    #1;
    chk("R5", "irq_mask", 32'(irq_mask), 32'(s[7:4]));
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 12'hFFF, 0, 0, 12'h000, pc, sr, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    exc_code = 12'hFFF; irq_req = 0; irq_ok = 0; irq_vec = 0;
    pc = 0; sr = 0; r15 = 32'h0C00_1000; vbr = 32'h8C00_0000; sleep = 0; ds = 0;
    m_load = 0; m_wake = 0; m_dsclr = 0;
    m_pc = 0; m_sr = 0; m_ssr = 0; m_spc = 0; m_sgr = 0; m_exp = 0; m_int = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all("R1");

    // R11: plain interrupt
    step("R11", 12'hFFF, 1, 1, 12'h320, 32'h8C00_2000, 32'h0000_0050, 0, 0);
    idle("R12");
    idle("R12");
    // R2: exception and interrupt together
    step("R2", 12'h180, 1, 1, 12'h400, 32'h8C00_2010, 32'h4000_0000, 0, 0);
    idle("R12");
    // R3: block bit remaps; 0x1E0 kept
    step("R3", 12'h0A0, 0, 0, 12'h0, 32'h8C00_3000, 32'h1000_8030, 0, 0);
    step("R3", 12'h1E0, 0, 0, 12'h0, 32'h8C00_3004, 32'h1000_0030, 0, 0);
    // R4: interrupt under block bit, awake then asleep
    step("R4", 12'hFFF, 1, 1, 12'h5A0, 32'h8C00_4000, 32'h1000_0000, 0, 0);
    step("R4", 12'hFFF, 1, 1, 12'h5A0, 32'h8C00_4000, 32'h1000_0000, 1, 0);
    // R5: priority unit refuses
    step("R5", 12'hFFF, 1, 0, 12'h620, 32'h8C00_5000, 32'h0000_00F0, 0, 0);
    // R6 R7: delay slot exception
    r15 = 32'h0C00_0FF0;
    step("R7", 12'h180, 0, 0, 12'h0, 32'h8C00_6002, 32'h0000_0010, 0, 1);
    idle("R6");
    // R8: reset-class codes
    step("R8", 12'h020, 0, 0, 12'h0, 32'h8C00_7000, 32'h0000_8030, 0, 0);
    step("R8", 12'h140, 0, 0, 12'h0, 32'h8C00_7004, 32'h0000_8000, 0, 1);
    // R9: TLB miss codes
    vbr = 32'h8000_1000;
    step("R9", 12'h040, 0, 0, 12'h0, 32'h0040_0000, 32'h0000_8000, 0, 0);
    step("R9", 12'h060, 0, 0, 12'h0, 32'h0040_0008, 32'h0000_0000, 0, 0);
    // R10: trap, with and without delay slot, and another general code
    step("R10", 12'h160, 0, 0, 12'h0, 32'h0040_0100, 32'h0000_0000, 0, 0);
    step("R10", 12'h160, 0, 0, 12'h0, 32'h0040_0200, 32'h0000_0000, 0, 1);
    step("R10", 12'h0E0, 1, 1, 12'h700, 32'h0040_0300, 32'h0000_0000, 0, 0);
    // R11: interrupt keeps EXPEVT, sleep cleared
    step("R11", 12'hFFF, 1, 1, 12'h3C0, 32'h0040_0400, 32'h0000_0020, 1, 1);
    idle("R12");
    idle("R12");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule